// File: doc/BRIEF.md
# Register-Mapped Serial UART With Status Flags

This block is a byte-wide asynchronous serial port attached to a small 16-bit register bus. Software writes a byte into the data register; the byte waits in a one-entry holding register, moves into a shift register as soon as the shifter is free, and leaves on the line as a frame of one start bit (0), eight data bits with the least significant first, and one stop bit (1). The line idles high. The receiver oversamples the incoming line sixteen times per bit, confirms the start bit at its middle, samples each data bit at its centre and then moves the finished byte into a receive data register.

A status word reports five conditions: transmitter running (bit 0), transmit holding register full (bit 1), receive data present (bit 2), receive overrun (bit 3) and framing error (bit 4). The framing flag is refreshed at every stop-bit sample, so a line held low (a break) is seen as a framing error. The bit rate comes from a divider register giving the number of system clocks per one-sixteenth of a bit.

Top module: `sreg_uart`

## Requirements
- R1: After reset every register reads 0 (status, data, data-high, divider) and the transmit line is 1.
- R2: A transmitted frame is a 0 start bit, eight data bits LSB first and a 1 stop bit; each bit lasts 16 × D system clocks, where D is the divider value.
- R3: A write to offset 1 while status bit 1 is 0 loads the holding register and sets bit 1 until the byte moves into the shifter; a write to offset 1 while bit 1 is 1 is ignored and that byte never appears on the line.
- R4: Status bit 0 is 1 while a frame is being shifted out; a byte waiting in the holding register starts right after the previous stop bit, with no idle time between the frames.
- R5: A received 8-bit frame is returned by a bus read of offset 1 in bits 7:0 with bits 15:8 at 0; status bit 2 is set when the byte arrives and cleared by that read.
- R6: A low pulse on the receive line that has ended before the middle of the start bit starts no reception.
- R7: Status bit 4 is written at each stop-bit sample: 1 when the line is 0 there, 0 otherwise; after a 0 stop bit the receiver waits for the line to return high before it looks for a new start bit.
- R8: Status bit 3 is written at each transfer into the receive data register: 1 if the register still held unread data, else 0; a read of offset 1 in the same clock as the transfer counts as having consumed the old byte, so bit 3 becomes 0 and bit 2 stays 1.
- R9: Offsets 2 (data-high) and 3 (divider) are plain 16-bit read/write registers; offset 0 (status) is read-only and a write to it changes nothing.
- R10: A divider value of 0 gives the same bit timing as a value of 1 (16 clocks per bit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 2 | Word offset: 0 status, 1 data, 2 data-high, 3 divider |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The case that needs care is a bus read of the data register landing in the very clock in which the receiver moves a new byte into that register, where the read must consume the old byte and the new one must stay flagged as unread without an overrun. The bench first measures, at the ports and with the divider at its one-clock-per-tick setting, how many clocks pass from the start bit to the new byte appearing, then replays an identical frame with a single one-cycle read placed on the transfer clock. It expects the read to return the older byte, the status to show data present with no overrun, and the register to then hold the newer byte.

// File: rtl/sreg_uart_pkg.sv
package sreg_uart_pkg;

    localparam int BUS_W = 16;
    localparam int OVS   = 16;
    localparam int OVS_W = $clog2(OVS);

    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_DATA = 2'd1,
        REG_DHI  = 2'd2,
        REG_DIV  = 2'd3
    } reg_sel_e;

    // Packed MSB first: bit 4 down to bit 0 of the status word
    typedef struct packed {
        logic frame_err;
        logic rx_ovr;
        logic rx_full;
        logic tx_full;
        logic tx_run;
    } stat_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BREAK
    } rx_state_e;

    function automatic logic [BUS_W-1:0] stat_word(input stat_t s);
        return {{(BUS_W - $bits(stat_t)){1'b0}}, s};
    endfunction

    function automatic logic [9:0] frame_bits(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
    assign tick_o = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R10
    div_min_chk: assert property (@(posedge clk) disable iff (rst)
        (div_i <= 1) |-> tick_o);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import sreg_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_byte_i,
    output logic       full_o,
    output logic       run_o,
    output logic       txd_o
);
    logic             hold_valid;
    logic [7:0]       hold_data;
    logic [9:0]       shreg;
    logic [3:0]       bitcnt;
    logic [OVS_W-1:0] ovs;
    logic             running;
    logic             bit_end;

    assign bit_end = running && tick_i && (ovs == OVS_W'(OVS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
            shreg      <= '1;
            bitcnt     <= '0;
            ovs        <= '0;
            running    <= 1'b0;
        end else begin
            if (!running) begin
                if (hold_valid) begin
                    shreg      <= frame_bits(hold_data);
                    running    <= 1'b1;
                    bitcnt     <= '0;
                    ovs        <= '0;
                    hold_valid <= 1'b0;
                end
            end else if (tick_i) begin
                if (bit_end) begin
                    ovs <= '0;
                    if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if (hold_valid) begin
                            shreg      <= frame_bits(hold_data);
                            hold_valid <= 1'b0;
                        end else begin
                            running <= 1'b0;
                        end
                    end else begin
                        shreg  <= {1'b1, shreg[9:1]};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end else begin
                    ovs <= ovs + 1'b1;
                end
            end
            if (wr_en_i && !hold_valid) begin
                hold_valid <= 1'b1;
                hold_data  <= wr_byte_i;
            end
        end
    end

    assign full_o = hold_valid;
    assign run_o  = running;
    assign txd_o  = running ? shreg[0] : 1'b1;

    // R4
    b2b_start_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_end && bitcnt == 4'd9 && hold_valid) |=> (run_o && !txd_o));

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && hold_valid) |=> (hold_data == $past(hold_data)));

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import sreg_uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       rxd_i,
    output logic       done_o,
    output logic [7:0] byte_o,
    output logic       ferr_o
);
    logic             sync1, line;
    rx_state_e        state;
    logic [OVS_W-1:0] cnt;
    logic [2:0]       bitn;
    logic [7:0]       sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            line  <= 1'b1;
        end else begin
            sync1 <= rxd_i;
            line  <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            sh     <= '0;
            done_o <= 1'b0;
            byte_o <= '0;
            ferr_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                RX_IDLE: if (tick_i && !line) begin
                    state <= RX_START;
                    cnt   <= '0;
                end
                RX_START: if (tick_i) begin
                    if (cnt == OVS_W'(OVS / 2 - 1)) begin
                        cnt  <= '0;
                        bitn <= '0;
                        state <= line ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: if (tick_i) begin
                    if (cnt == OVS_W'(OVS - 1)) begin
                        cnt <= '0;
                        sh  <= {line, sh[7:1]};
                        if (bitn == 3'd7) state <= RX_STOP;
                        else              bitn  <= bitn + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: if (tick_i) begin
                    if (cnt == OVS_W'(OVS - 1)) begin
                        cnt    <= '0;
                        done_o <= 1'b1;
                        byte_o <= sh;
                        ferr_o <= !line;
                        state  <= line ? RX_IDLE : RX_BREAK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_BREAK: if (line) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    break_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_BREAK && !line) |=> (state == RX_BREAK));

endmodule

// File: rtl/sreg_uart.sv
module sreg_uart
    import sreg_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             rxd,
    output logic             txd
);
    reg_sel_e         rsel;
    logic             rd_data, wr_data, wr_dhi, wr_div;
    logic             tick;
    logic [DIV_W-1:0] div_q;
    logic [BUS_W-1:0] dhi_q;
    logic [7:0]       rx_data;
    logic             rx_full, rx_ovr, rx_ferr_q;
    logic             rx_done, rx_ferr;
    logic [7:0]       rx_byte;
    logic             tx_full, tx_run;
    stat_t            stat;

    assign rsel    = reg_sel_e'(bus_addr);
    assign rd_data = bus_sel && !bus_wr && (rsel == REG_DATA);
    assign wr_data = bus_sel &&  bus_wr && (rsel == REG_DATA);
    assign wr_dhi  = bus_sel &&  bus_wr && (rsel == REG_DHI);
    assign wr_div  = bus_sel &&  bus_wr && (rsel == REG_DIV);

    uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_q),
        .tick_o (tick)
    );

    uart_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .wr_en_i   (wr_data),
        .wr_byte_i (bus_wdata[7:0]),
        .full_o    (tx_full),
        .run_o     (tx_run),
        .txd_o     (txd)
    );

    uart_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .rxd_i  (rxd),
        .done_o (rx_done),
        .byte_o (rx_byte),
        .ferr_o (rx_ferr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            dhi_q <= '0;
        end else begin
            if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
            if (wr_dhi) dhi_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data   <= '0;
            rx_full   <= 1'b0;
            rx_ovr    <= 1'b0;
            rx_ferr_q <= 1'b0;
        end else if (rx_done) begin
            rx_data   <= rx_byte;
            rx_full   <= 1'b1;
            rx_ovr    <= rx_full && !rd_data;
            rx_ferr_q <= rx_ferr;
        end else if (rd_data) begin
            rx_full <= 1'b0;
        end
    end

    always_comb begin
        stat.frame_err = rx_ferr_q;
        stat.rx_ovr    = rx_ovr;
        stat.rx_full   = rx_full;
        stat.tx_full   = tx_full;
        stat.tx_run    = tx_run;
    end

    always_comb begin
        unique case (rsel)
            REG_STAT: bus_rdata = stat_word(stat);
            REG_DATA: bus_rdata = {{(BUS_W-8){1'b0}}, rx_data};
            REG_DHI:  bus_rdata = dhi_q;
            REG_DIV:  bus_rdata = BUS_W'(div_q);
            default:  bus_rdata = '0;
        endcase
    end

    // R8
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_full && !rd_data) |=> stat.rx_ovr);

    // R8
    ovr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && (!rx_full || rd_data)) |=> (!stat.rx_ovr && stat.rx_full));

    // R5
    full_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx_done) |=> !stat.rx_full);

    // R7
    ferr_upd_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> (stat.frame_err == $past(rx_ferr)));

endmodule

// File: tb/sreg_uart_bench.sv
module sreg_uart_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    sreg_uart u_sreg_uart (
        .clk (clk), .rst (rst), .bus_sel (bus_sel), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .rxd (rxd), .txd (txd)
    );

    function automatic logic [9:0] exp_frame(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

    function automatic logic [15:0] exp_stat(input bit fe, input bit ov, input bit rf,
                                             input bit tf, input bit tr);
        return {11'd0, fe, ov, rf, tf, tr};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic stop_v, input int bc);
        logic [9:0] f;
        f = exp_frame(b);
        f[9] = stop_v;
        for (int i = 0; i < 10; i++) begin
            rxd = f[i];
            repeat (bc) @(negedge clk);
        end
        rxd = 1'b1;
    endtask

    task automatic capture(input int n, input int bc, output logic [29:0] bits);
        bits = '1;
        while (txd !== 1'b0) @(negedge clk);
        repeat (bc / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bits[i] = txd;
            if (i < n - 1) repeat (bc) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, s0;
        logic [29:0] bits;
        logic [7:0]  a, b, c;
        int lat, bc, dv;
        bit all_high;
        void'($urandom(32'h5eed));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        bus_read(2'd0, v); chk("R1 status", v, 16'h0000);
        bus_read(2'd1, v); chk("R1 data", v, 16'h0000);
        bus_read(2'd2, v); chk("R1 data-high", v, 16'h0000);
        bus_read(2'd3, v); chk("R1 divider", v, 16'h0000);
        chk("R1 txd idle", txd, 1'b1);

        // R2 R3 R4 R10: divider 0 -> 16 clocks per bit, back-to-back, ignored write
        a = 8'hA5; b = 8'h3C; c = 8'hE7;
        fork
            capture(20, 16, bits);
            begin
                bus_write(2'd1, {8'h00, a});
                peek(2'd0, v); chk("R3 full after write", v, exp_stat(0,0,0,1,0));
                repeat (3) @(negedge clk);
                peek(2'd0, v); chk("R4 running, holding free", v, exp_stat(0,0,0,0,1));
                bus_write(2'd1, {8'h00, b});
                peek(2'd0, v); chk("R3 R4 full and running", v, exp_stat(0,0,0,1,1));
                bus_write(2'd1, {8'h00, c});
                peek(2'd0, v); chk("R3 write while full", v, exp_stat(0,0,0,1,1));
            end
        join
        chk("R2 R10 first frame", bits[9:0], exp_frame(a));
        chk("R4 second frame without gap", bits[19:10], exp_frame(b));
        repeat (16) @(negedge clk);
        peek(2'd0, v); chk("R4 idle after frames", v, exp_stat(0,0,0,0,0));
        all_high = 1'b1;
        repeat (200) begin
            @(negedge clk);
            if (txd !== 1'b1) all_high = 1'b0;
        end
        chk("R3 ignored byte never sent", all_high, 1'b1);

        // R5: receive and read
        rx_send(8'hC3, 1'b1, 16);
        repeat (4) @(negedge clk);
        peek(2'd0, v); chk("R5 rx full set", v, exp_stat(0,0,1,0,0));
        bus_read(2'd1, v); chk("R5 data in low byte, zero high", v, 16'h00C3);
        peek(2'd0, v); chk("R5 rx full cleared by read", v, exp_stat(0,0,0,0,0));

        // R8: overrun set, then cleared by next clean transfer
        rx_send(8'h11, 1'b1, 16);
        rx_send(8'h22, 1'b1, 16);
        repeat (4) @(negedge clk);
        peek(2'd0, v); chk("R8 overrun set", v, exp_stat(0,1,1,0,0));
        bus_read(2'd1, v); chk("R8 newest byte kept", v, 16'h0022);
        rx_send(8'h33, 1'b1, 16);
        repeat (4) @(negedge clk);
        peek(2'd0, v); chk("R8 overrun cleared", v, exp_stat(0,0,1,0,0));
        bus_read(2'd1, v);

        // R7: zero stop bit, then a good frame
        rx_send(8'h5A, 1'b0, 16);
        repeat (4) @(negedge clk);
        peek(2'd0, v); chk("R7 framing error set", v, exp_stat(1,0,1,0,0));
        bus_read(2'd1, v); chk("R7 byte of bad frame", v, 16'h005A);
        repeat (32) @(negedge clk);
        rx_send(8'h96, 1'b1, 16);
        repeat (4) @(negedge clk);
        peek(2'd0, v); chk("R7 framing error cleared", v, exp_stat(0,0,1,0,0));
        bus_read(2'd1, v); chk("R7 good byte after break", v, 16'h0096);

        // R6: short low glitch
        rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        peek(2'd0, v); chk("R6 glitch rejected", v, exp_stat(0,0,0,0,0));

        // R8: read in the same cycle as the transfer
        a = 8'h4E; b = 8'hB1;
        rx_send(a, 1'b1, 16);
        repeat (20) @(negedge clk);
        lat = 0;
        fork
            rx_send(b, 1'b1, 16);
            begin
                v = 16'h0000;
                while (v[7:0] !== b) begin
                    @(negedge clk);
                    lat++;
                    peek(2'd1, v);
                end
            end
        join
        repeat (4) @(negedge clk);
        peek(2'd0, v); chk("R8 overrun in measuring run", v, exp_stat(0,1,1,0,0));
        bus_read(2'd1, v);
        a = 8'h69; b = 8'h0F;
        rx_send(a, 1'b1, 16);
        repeat (20) @(negedge clk);
        fork
            rx_send(b, 1'b1, 16);
            begin
                repeat (lat - 1) @(negedge clk);
                bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd1;
                #1 v = bus_rdata;
                @(negedge clk);
                bus_sel = 1'b0;
                chk("R8 colliding read returns older byte", v, {8'h00, a});
            end
        join
        repeat (4) @(negedge clk);
        peek(2'd0, v); chk("R8 collision: full, no overrun", v, exp_stat(0,0,1,0,0));
        peek(2'd1, v); chk("R8 collision: newer byte held", v, {8'h00, b});
        bus_read(2'd1, v);

        // R9: plain registers, read-only status
        bus_write(2'd3, 16'h0003);
        bus_read(2'd3, v); chk("R9 divider read back", v, 16'h0003);
        bus_write(2'd2, 16'hBEEF);
        bus_read(2'd2, v); chk("R9 data-high read back", v, 16'hBEEF);
        bus_read(2'd0, s0);
        bus_write(2'd0, 16'hFFFF);
        bus_read(2'd0, v); chk("R9 status write ignored", v, s0);
        bus_read(2'd2, v); chk("R9 data-high untouched by status write", v, 16'hBEEF);

        // R2 R5: random bytes and dividers
        for (int k = 0; k < 6; k++) begin
            dv = 1 + int'($urandom % 3);
            bc = 16 * dv;
            a = 8'($urandom);
            b = 8'($urandom);
            bus_write(2'd3, 16'(dv));
            fork
                capture(10, bc, bits);
                bus_write(2'd1, {8'h00, a});
            join
            chk("R2 random tx frame", bits[9:0], exp_frame(a));
            repeat (bc) @(negedge clk);
            rx_send(b, 1'b1, bc);
            repeat (4 * dv + 4) @(negedge clk);
            bus_read(2'd1, v); chk("R5 random rx byte", v, {8'h00, b});
            peek(2'd0, v); chk("R5 random status idle", v, exp_stat(0,0,0,0,0));
            repeat (int'($urandom % 40)) @(negedge clk);
        end

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule